// File: doc/BRIEF.md
# 16-bit Address Arithmetic Unit

This block does the 16-bit register-pair and stack-pointer arithmetic for a small 8-bit processor. One operation code picks one of five jobs: step a register pair up by one, step it down by one, add a second pair into HL, add a signed byte offset to SP, or form SP plus a signed byte offset and send it to HL. The block returns the 16-bit result, the new flag nibble and a code that names which register the result is for. The register file that applies the write lives outside.

Each job has its own flag rule. The one-step jobs leave every flag as it was. The pair add keeps the zero flag, clears the subtract flag, and takes half-carry and carry from the upper byte. Both offset jobs clear zero and subtract, and take half-carry and carry from the unsigned addition of the low byte of SP and the raw offset byte. Outputs are registered, so a result shows up one clock after its operands are applied.

Top module: `addr16_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs become `result` = 0, `flags_out` = 0 and `dest` = 0 (no write), whatever the other inputs are.
- R2: Operation code 0 (step up) gives `result` = `opnd_a` + 1 modulo 65536 and `dest` = 1 (the addressed pair). `flags_out` equals `flags_in`. The flag nibble is z in bit 3, n in bit 2, h in bit 1 and c in bit 0.
- R3: Operation code 1 (step down) gives `result` = `opnd_a` - 1 modulo 65536, `dest` = 1, and `flags_out` equal to `flags_in`.
- R4: Operation code 2 (pair into HL, with `opnd_a` = HL and `opnd_b` = the second pair) gives `result` = `opnd_a` + `opnd_b` modulo 65536 and `dest` = 2 (HL). z is copied from `flags_in` even when the sum is zero. n = 0, h = carry out of bit 11 and c = carry out of bit 15.
- R5: Operation code 3 (offset into SP, with `opnd_a` = SP) gives `result` = `opnd_a` + sign-extended `disp` and `dest` = 3 (SP). z = 0 and n = 0. h = carry out of bit 3 and c = carry out of bit 7 of `opnd_a[7:0]` + `disp`, taken as unsigned.
- R6: Operation code 4 (SP plus offset into HL) does the same arithmetic and uses the same flag rule as R5, but gives `dest` = 2 (HL).
- R7: A negative offset is applied as a signed value: `disp` = 0xFF gives SP - 1 and `disp` = 0x80 gives SP - 128. The low-byte carries still come from the raw byte.
- R8: `result`, `flags_out` and `dest` change only at a rising clock edge. They reflect the inputs sampled at that edge and hold their values until the next edge.
- R9: Operation codes 5 to 7 give `result` = 0, `dest` = 0 (no write), and `flags_out` equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code (0 to 4 used) |
| opnd_a | input | 16 | Pair to step, HL, or SP, depending on the operation |
| opnd_b | input | 16 | Second pair for the pair add |
| disp | input | 8 | Signed byte offset |
| flags_in | input | 4 | Current flags {z,n,h,c} |
| result | output | 16 | Registered 16-bit result |
| flags_out | output | 4 | Registered new flags {z,n,h,c} |
| dest | output | 2 | Registered destination: 0 none, 1 pair, 2 HL, 3 SP |

## Verification
The hardest cases to reach are the ones where the low-byte flags disagree with the sign of the 16-bit result. A negative offset can lower SP and still set both h and c, as in 0x0005 + 0xFF. The mirror case is a pair add that wraps to zero while z must stay at its old value. The vector table aims at these cases with operands chosen on purpose. It includes offsets of 0xFF and 0x80, low bytes just under a nibble or byte boundary, and incoming flags set opposite to what the flag rule forces, so that a flag that is wrongly held or wrongly forced shows up.

// File: rtl/addr16_pkg.sv
package addr16_pkg;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned DST_W  = 2;

  localparam logic [OP_W-1:0] OP_STEP_UP   = 3'd0;
  localparam logic [OP_W-1:0] OP_STEP_DOWN = 3'd1;
  localparam logic [OP_W-1:0] OP_PAIR_ADD  = 3'd2;
  localparam logic [OP_W-1:0] OP_SP_OFS    = 3'd3;
  localparam logic [OP_W-1:0] OP_HL_SPOFS  = 3'd4;

  localparam logic [DST_W-1:0] DST_NONE = 2'd0;
  localparam logic [DST_W-1:0] DST_PAIR = 2'd1;
  localparam logic [DST_W-1:0] DST_HL   = 2'd2;
  localparam logic [DST_W-1:0] DST_SP   = 2'd3;

  localparam int unsigned FZ = 3;
  localparam int unsigned FN = 2;
  localparam int unsigned FH = 1;
  localparam int unsigned FC = 0;
endpackage

// File: rtl/addr16_operand_sel.sv
module addr16_operand_sel
  import addr16_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DISP_W-1:0] disp,
  output logic [DATA_W-1:0] addend
);
  localparam int unsigned EXT_W = DATA_W - DISP_W;

  logic [DATA_W-1:0] disp_ext;
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

  always_comb begin
    unique case (op_sel)
      OP_STEP_UP:               addend = DATA_W'(1);
      OP_STEP_DOWN:             addend = '1;
      OP_PAIR_ADD:              addend = opnd_b;
      OP_SP_OFS, OP_HL_SPOFS:   addend = disp_ext;
      default:                  addend = '0;
    endcase
  end
endmodule

// File: rtl/addr16_adder.sv
module addr16_adder #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic              co_lo_half,
  output logic              co_lo,
  output logic              co_hi_half,
  output logic              co_hi
);
  localparam int unsigned LO_HALF = DISP_W / 2;
  localparam int unsigned HI_HALF = DATA_W - 4;

  logic [DATA_W:0] cy;
  assign cy[0] = 1'b0;

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    assign sum[k]  = a[k] ^ b[k] ^ cy[k];
    assign cy[k+1] = (a[k] & b[k]) | ((a[k] ^ b[k]) & cy[k]);
  end

  assign co_lo_half = cy[LO_HALF];
  assign co_lo      = cy[DISP_W];
  assign co_hi_half = cy[HI_HALF];
  assign co_hi      = cy[DATA_W];
endmodule

// File: rtl/addr16_flag_policy.sv
module addr16_flag_policy
  import addr16_pkg::*;
(
  input  logic [OP_W-1:0]   op_sel,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              co_lo_half,
  input  logic              co_lo,
  input  logic              co_hi_half,
  input  logic              co_hi,
  output logic [FLAG_W-1:0] flags_nx,
  output logic [DST_W-1:0]  dest_nx,
  output logic              op_ok
);
  always_comb begin
    flags_nx = flags_in;
    dest_nx  = DST_NONE;
    op_ok    = 1'b1;
    unique case (op_sel)
      OP_STEP_UP, OP_STEP_DOWN: dest_nx = DST_PAIR;
      OP_PAIR_ADD: begin
        dest_nx      = DST_HL;
        flags_nx[FN] = 1'b0;
        flags_nx[FH] = co_hi_half;
        flags_nx[FC] = co_hi;
      end
      OP_SP_OFS, OP_HL_SPOFS: begin
        dest_nx      = (op_sel == OP_SP_OFS) ? DST_SP : DST_HL;
        flags_nx[FZ] = 1'b0;
        flags_nx[FN] = 1'b0;
        flags_nx[FH] = co_lo_half;
        flags_nx[FC] = co_lo;
      end
      default: op_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/addr16_alu.sv
module addr16_alu
  import addr16_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DISP_W-1:0] disp,
  input  logic [3:0]        flags_in,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags_out,
  output logic [1:0]        dest
);
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sum;
  logic              co_lo_half, co_lo, co_hi_half, co_hi;
  logic [FLAG_W-1:0] flags_nx;
  logic [DST_W-1:0]  dest_nx;
  logic              op_ok;

  addr16_operand_sel #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_sel (
    .op_sel (op_sel),
    .opnd_b (opnd_b),
    .disp   (disp),
    .addend (addend)
  );

  addr16_adder #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_add (
    .a          (opnd_a),
    .b          (addend),
    .sum        (sum),
    .co_lo_half (co_lo_half),
    .co_lo      (co_lo),
    .co_hi_half (co_hi_half),
    .co_hi      (co_hi)
  );

  addr16_flag_policy u_pol (
    .op_sel     (op_sel),
    .flags_in   (flags_in),
    .co_lo_half (co_lo_half),
    .co_lo      (co_lo),
    .co_hi_half (co_hi_half),
    .co_hi      (co_hi),
    .flags_nx   (flags_nx),
    .dest_nx    (dest_nx),
    .op_ok      (op_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flags_out <= '0;
      dest      <= DST_NONE;
    end else begin
      result    <= op_ok ? sum : '0;
      flags_out <= flags_nx;
      dest      <= dest_nx;
    end
  end
endmodule

// File: rtl/addr16_alu_chk.sv
module addr16_alu_chk
  import addr16_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DISP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_sel,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DISP_W-1:0] disp,
  input logic [3:0]        flags_in,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags_out,
  input logic [1:0]        dest
);
  localparam int unsigned EXT_W = DATA_W - DISP_W;

  logic primed;
  always_ff @(posedge clk) primed <= !rst;

  AST_STEP_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    primed && ($past(op_sel) == OP_STEP_UP || $past(op_sel) == OP_STEP_DOWN)
      |-> flags_out == $past(flags_in)); // R2
  AST_STEP_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_sel) == OP_STEP_UP
      |-> result == DATA_W'($past(opnd_a) + 1) && dest == DST_PAIR); // R2
  AST_STEP_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_sel) == OP_STEP_DOWN
      |-> result == DATA_W'($past(opnd_a) - 1) && dest == DST_PAIR); // R3
  AST_PAIR_Z_HELD: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_sel) == OP_PAIR_ADD
      |-> flags_out[FZ] == $past(flags_in[FZ]) && !flags_out[FN]
          && result == DATA_W'($past(opnd_a) + $past(opnd_b))); // R4
  AST_OFS_ZN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    primed && ($past(op_sel) == OP_SP_OFS || $past(op_sel) == OP_HL_SPOFS)
      |-> flags_out[FZ:FN] == 2'b00); // R5
  AST_HL_SPOFS_DEST: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_sel) == OP_HL_SPOFS
      |-> dest == DST_HL && result == DATA_W'($past(opnd_a)
          + {{EXT_W{$past(disp[DISP_W-1])}}, $past(disp)})); // R6
  AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_sel) > OP_HL_SPOFS
      |-> dest == DST_NONE && result == '0 && flags_out == $past(flags_in)); // R9
endmodule

bind addr16_alu addr16_alu_chk chk_i (.*);

// File: tb/addr16_alu_tb_top.sv
`timescale 1ns/1ps
module addr16_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic [7:0]  disp = '0;
  logic [3:0]  flags_in = '0;
  logic [15:0] result;
  logic [3:0]  flags_out;
  logic [1:0]  dest;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  addr16_alu dut_i (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [7:0]  d;
    logic [3:0]  fin;
    logic [15:0] res;
    logic [3:0]  fl;
    logic [1:0]  dst;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 3'd0, 16'h1234, 16'h0000, 8'h00, 4'b1010, 16'h1235, 4'b1010, 2'd1}, // R2
    '{4'd2, 3'd0, 16'hFFFF, 16'h0000, 8'h00, 4'b0101, 16'h0000, 4'b0101, 2'd1}, // R2 wrap
    '{4'd3, 3'd1, 16'h0000, 16'h0000, 8'h00, 4'b1111, 16'hFFFF, 4'b1111, 2'd1}, // R3 wrap
    '{4'd3, 3'd1, 16'h8000, 16'h0000, 8'h00, 4'b0000, 16'h7FFF, 4'b0000, 2'd1}, // R3
    '{4'd4, 3'd2, 16'h0FFF, 16'h0001, 8'h00, 4'b1100, 16'h1000, 4'b1010, 2'd2}, // R4 h from bit 11
    '{4'd4, 3'd2, 16'h8000, 16'h8000, 8'h00, 4'b0000, 16'h0000, 4'b0001, 2'd2}, // R4 z held at 0
    '{4'd4, 3'd2, 16'hFFFF, 16'h0001, 8'h00, 4'b1000, 16'h0000, 4'b1011, 2'd2}, // R4
    '{4'd5, 3'd3, 16'hFFF8, 16'h0000, 8'h08, 4'b1111, 16'h0000, 4'b0011, 2'd3}, // R5
    '{4'd7, 3'd3, 16'h1000, 16'h0000, 8'hFF, 4'b0000, 16'h0FFF, 4'b0000, 2'd3}, // R7
    '{4'd7, 3'd3, 16'h0005, 16'h0000, 8'hFF, 4'b0000, 16'h0004, 4'b0011, 2'd3}, // R7
    '{4'd7, 3'd3, 16'h0100, 16'h0000, 8'h80, 4'b1100, 16'h0080, 4'b0000, 2'd3}, // R7
    '{4'd6, 3'd4, 16'h00FF, 16'h0000, 8'h01, 4'b1100, 16'h0100, 4'b0011, 2'd2}, // R6
    '{4'd6, 3'd4, 16'h1234, 16'h0000, 8'h00, 4'b1111, 16'h1234, 4'b0000, 2'd2}, // R6
    '{4'd9, 3'd5, 16'h1234, 16'h5678, 8'h12, 4'b0110, 16'h0000, 4'b0110, 2'd0}, // R9
    '{4'd9, 3'd7, 16'hFFFF, 16'hFFFF, 8'hFF, 4'b1001, 16'h0000, 4'b1001, 2'd0}  // R9
  };

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    op_sel = v.op; opnd_a = v.a; opnd_b = v.b; disp = v.d; flags_in = v.fin;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "result", result, 16'h0);
    check("R1", "flags", {12'h0, flags_out}, 16'h0);
    check("R1", "dest", {14'h0, dest}, 16'h0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      apply(VECS[i]);
      check(tag, "result", result, VECS[i].res);
      check(tag, "flags", {12'h0, flags_out}, {12'h0, VECS[i].fl});
      check(tag, "dest", {14'h0, dest}, {14'h0, VECS[i].dst});
    end

    // R8: new inputs do not reach the outputs before the edge
    apply('{4'd8, 3'd1, 16'h0010, 16'h0, 8'h0, 4'b0000, 16'h000F, 4'b0000, 2'd1});
    @(negedge clk);
    op_sel = 3'd0; opnd_a = 16'h00FF; flags_in = 4'b1111;
    #2;
    check("R8", "result held", result, 16'h000F);
    check("R8", "flags held", {12'h0, flags_out}, 16'h0);
    @(posedge clk); #1;
    check("R8", "result after edge", result, 16'h0100);
    check("R8", "flags after edge", {12'h0, flags_out}, 16'h000F);

    // R1: reset overrides a valid operation
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R1", "result in reset", result, 16'h0);
    check("R1", "flags in reset", {12'h0, flags_out}, 16'h0);
    check("R1", "dest in reset", {14'h0, dest}, 16'h0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check("R2", "after reset release", result, 16'h0100);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule